// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out, in one combinational step, where an instruction's memory operand lives. It serves a 32-bit load/store processor. It takes a decoded addressing-mode code, two register values (a base register and an index register), the already-advanced program counter, a short signed constant from the instruction word and an operand-size bit. From these it forms the effective address. It raises a flag when the operand is the constant itself rather than a memory location.

For the post-increment and pre-decrement modes the block also supplies the new value of the base register and an enable for writing it back. Both are produced in the same cycle as the address. The surrounding pipeline reads the outputs directly and stores them wherever it needs them. The block has no state, so there are no state names or transitions. The mode code alone selects the behaviour, as given in the requirements below.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode code 3 (indexed) gives an address equal to the sign-extended 16-bit constant plus the base register.
- R2: Mode code 4 (two-register) gives an address equal to the base register plus the index register.
- R3: Mode code 5 (two-register with offset) gives an address equal to the sign-extended constant plus the base register plus the index register.
- R4: Mode code 6 (PC-relative) gives an address equal to the program-counter input plus the sign-extended constant. The program-counter input already points past the current instruction, so a constant of -16 from a PC of 1016 yields 1000.
- R5: Mode code 2 (register-indirect) gives an address equal to the base register unchanged.
- R6: Mode code 7 (post-increment) gives an address equal to the old base register. The write-back value is the base register plus the operand step.
- R7: Mode code 8 (pre-decrement) gives the base register minus the operand step. That same value appears on both the address and the write-back outputs.
- R8: The operand step is 1 when the size input is 0 (byte) and 4 when it is 1 (word).
- R9: Mode code 1 (absolute) gives an address equal to the 16-bit constant zero-extended to 32 bits, whatever the register values are.
- R10: Mode code 0 (immediate) raises the immediate flag and drives the address to 0. No other mode code raises the flag.
- R11: The write-back enable is high only for mode codes 7 and 8, and it follows the mode input within the same cycle. When the enable is low, the write-back value is 0.
- R12: All address sums and differences wrap modulo 2^32, and no overflow is signalled.
- R13: Mode codes 9 to 15 are unused. They give address 0 with the immediate flag and the write-back enable both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 4 | Addressing-mode code (0 to 8 used) |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| pc_i | input | 32 | Already-advanced program counter |
| ofs_i | input | 16 | Instruction constant |
| size_word_i | input | 1 | Operand size: 0 byte, 1 word |
| ea_o | output | 32 | Effective address |
| imm_o | output | 1 | Operand is the constant itself |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_data_o | output | 32 | New base register value |

## Verification
The effective address and the register write-back are both produced in the same cycle during post-increment and pre-decrement, and the two must relate correctly. The bench drives each of those modes with both operand sizes and compares the two outputs against each other and against values it computes itself. In post-increment the address must be the old register value while the write-back is one step higher. In pre-decrement the two outputs must be identical. Base values near 0 and near 2^32 check that this pairing still holds across the wrap.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_ADDR_W = 32;
    localparam int EA_OFS_W  = 16;
    localparam int EA_MODE_W = 4;

    typedef enum logic [EA_MODE_W-1:0] {
        AM_IMMED   = 4'd0,
        AM_ABSOL   = 4'd1,
        AM_INDIR   = 4'd2,
        AM_INDEX   = 4'd3,
        AM_BASEIX  = 4'd4,
        AM_BASEIXO = 4'd5,
        AM_PCREL   = 4'd6,
        AM_POSTINC = 4'd7,
        AM_PREDEC  = 4'd8
    } ea_mode_e;

    localparam int STEP_BYTE = 1;
    localparam int STEP_WORD = 4;

endpackage

// File: rtl/ea_ofs_ext.sv
module ea_ofs_ext #(
    parameter int IN_W   = 16,
    parameter int OUT_W  = 32,
    parameter bit SIGNED = 1'b1
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [OUT_W-1:0] ext_o
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (SIGNED) begin : g_sext
            assign ext_o = {{PAD_W{raw_i[IN_W-1]}}, raw_i};
        end else begin : g_zext
            assign ext_o = {{PAD_W{1'b0}}, raw_i};
        end
    endgenerate
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o
);
    // Carries above bit W-1 are dropped: wrap modulo 2^W (R12).
    assign sum_o = a_i + b_i + c_i;
endmodule

// File: rtl/ea_step_unit.sv
module ea_step_unit #(
    parameter int W     = 32,
    parameter int SMALL = 1,
    parameter int LARGE = 4
) (
    input  logic [W-1:0] reg_i,
    input  logic         large_i,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o
);
    localparam logic [W-1:0] SMALL_V = W'(SMALL);
    localparam logic [W-1:0] LARGE_V = W'(LARGE);

    logic [W-1:0] step;

    always_comb begin
        step  = large_i ? LARGE_V : SMALL_V;
        inc_o = reg_i + step;
        dec_o = reg_i - step;
    end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W = ea_pkg::EA_ADDR_W,
    parameter int OFS_W  = ea_pkg::EA_OFS_W,
    parameter int MODE_W = ea_pkg::EA_MODE_W
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              size_word_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              imm_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_data_o
);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    logic [ADDR_W-1:0] ofs_sx;
    logic [ADDR_W-1:0] ofs_zx;
    logic [ADDR_W-1:0] op_a;
    logic [ADDR_W-1:0] op_b;
    logic [ADDR_W-1:0] op_c;
    logic [ADDR_W-1:0] sum3;
    logic [ADDR_W-1:0] reg_inc;
    logic [ADDR_W-1:0] reg_dec;

    ea_ofs_ext #(.IN_W(OFS_W), .OUT_W(ADDR_W), .SIGNED(1'b1)) u_sext (
        .raw_i (ofs_i),
        .ext_o (ofs_sx)
    );

    ea_ofs_ext #(.IN_W(OFS_W), .OUT_W(ADDR_W), .SIGNED(1'b0)) u_zext (
        .raw_i (ofs_i),
        .ext_o (ofs_zx)
    );

    ea_step_unit #(.W(ADDR_W), .SMALL(STEP_BYTE), .LARGE(STEP_WORD)) u_step (
        .reg_i   (base_i),
        .large_i (size_word_i),
        .inc_o   (reg_inc),
        .dec_o   (reg_dec)
    );

    ea_adder3 #(.W(ADDR_W)) u_add (
        .a_i   (op_a),
        .b_i   (op_b),
        .c_i   (op_c),
        .sum_o (sum3)
    );

    // Operand selection for the shared three-input adder.
    always_comb begin
        op_a = ZERO;
        op_b = ZERO;
        op_c = ZERO;
        unique case (mode_i)
            AM_INDEX:   begin op_a = base_i; op_b = ofs_sx;                   end
            AM_BASEIX:  begin op_a = base_i; op_b = index_i;                  end
            AM_BASEIXO: begin op_a = base_i; op_b = index_i; op_c = ofs_sx;   end
            AM_PCREL:   begin op_a = pc_i;   op_b = ofs_sx;                   end
            default:    begin op_a = ZERO;                                    end
        endcase
    end

    // Output decode per mode.
    always_comb begin
        ea_o      = ZERO;
        imm_o     = 1'b0;
        wb_en_o   = 1'b0;
        wb_data_o = ZERO;
        unique case (mode_i)
            AM_IMMED:   imm_o = 1'b1;
            AM_ABSOL:   ea_o  = ofs_zx;
            AM_INDIR:   ea_o  = base_i;
            AM_INDEX,
            AM_BASEIX,
            AM_BASEIXO,
            AM_PCREL:   ea_o  = sum3;
            AM_POSTINC: begin
                ea_o      = base_i;
                wb_en_o   = 1'b1;
                wb_data_o = reg_inc;
            end
            AM_PREDEC:  begin
                ea_o      = reg_dec;
                wb_en_o   = 1'b1;
                wb_data_o = reg_dec;
            end
            default:    ea_o = ZERO;
        endcase
    end

    // Checks across separately driven outputs.
    always_comb begin
        if (!$isunknown({mode_i, base_i, size_word_i, ea_o, imm_o, wb_en_o, wb_data_o})) begin
            assert_flags_exclusive_R11: assert ($onehot0({imm_o, wb_en_o}))
                else $error("imm and write-back both high");
            assert_imm_zero_addr_R10: assert (!imm_o || ea_o == ZERO)
                else $error("immediate with nonzero address");
            assert_predec_match_R7: assert (!(wb_en_o && mode_i == AM_PREDEC) || ea_o == wb_data_o)
                else $error("pre-decrement address differs from write-back");
            assert_postinc_step_R6: assert (!(wb_en_o && mode_i == AM_POSTINC)
                    || (wb_data_o - ea_o) == (size_word_i ? ADDR_W'(STEP_WORD) : ADDR_W'(STEP_BYTE)))
                else $error("post-increment step wrong");
            assert_wb_off_zero_R11: assert (wb_en_o || wb_data_o == ZERO)
                else $error("write-back data nonzero while disabled");
        end
    end
endmodule

// File: tb/tb_ea_gen_unit.sv
module tb_ea_gen_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [3:0]  mode_i = 4'd15;
    logic [31:0] base_i = '0;
    logic [31:0] index_i = '0;
    logic [31:0] pc_i = '0;
    logic [15:0] ofs_i = '0;
    logic        size_word_i = 1'b0;
    logic [31:0] ea_o;
    logic        imm_o;
    logic        wb_en_o;
    logic [31:0] wb_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen_unit dut (
        .mode_i      (mode_i),
        .base_i      (base_i),
        .index_i     (index_i),
        .pc_i        (pc_i),
        .ofs_i       (ofs_i),
        .size_word_i (size_word_i),
        .ea_o        (ea_o),
        .imm_o       (imm_o),
        .wb_en_o     (wb_en_o),
        .wb_data_o   (wb_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                         input logic [31:0] p, input logic [15:0] o, input logic w);
        @(negedge clk);
        mode_i = m; base_i = b; index_i = x; pc_i = p; ofs_i = o; size_word_i = w;
        #1;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic t_idle_R13();
        for (int m = 9; m < 16; m++) begin
            apply(4'(m), 32'h1234, 32'h55, 32'h999, 16'h7, 1'b1);
            chk("R13 ea", ea_o, 32'h0);
            chk("R13 flags", {30'd0, imm_o, wb_en_o}, 32'h0);
        end
    endtask

    task automatic t_immediate_R10();
        apply(4'd0, 32'hAAAA_0000, 32'h1, 32'h2, 16'h00C8, 1'b1);
        chk("R10 imm", {31'd0, imm_o}, 32'h1);
        chk("R10 ea", ea_o, 32'h0);
        chk("R11 wb_en imm", {31'd0, wb_en_o}, 32'h0);
    endtask

    task automatic t_absolute_R9();
        apply(4'd1, 32'hDEAD_BEEF, 32'h77, 32'h88, 16'h80C8, 1'b0);
        chk("R9 ea", ea_o, 32'h0000_80C8);
        chk("R10 no imm", {31'd0, imm_o}, 32'h0);
    endtask

    task automatic t_indirect_R5();
        apply(4'd2, 32'h0000_2000, 32'h4, 32'h8, 16'h10, 1'b1);
        chk("R5 ea", ea_o, 32'h0000_2000);
        chk("R11 wb_en", {31'd0, wb_en_o}, 32'h0);
        chk("R11 wb_data", wb_data_o, 32'h0);
    endtask

    task automatic t_index_R1();
        apply(4'd3, 32'd1000, 32'h0, 32'h0, 16'd20, 1'b1);
        chk("R1 pos", ea_o, 32'd1020);
        apply(4'd3, 32'd1000, 32'h0, 32'h0, 16'hFFF0, 1'b1);
        chk("R1 neg", ea_o, 32'd984);
    endtask

    task automatic t_baseidx_R2_R3();
        apply(4'd4, 32'h0001_0000, 32'h0000_0030, 32'h0, 16'h7FFF, 1'b0);
        chk("R2 sum", ea_o, 32'h0001_0030);
        apply(4'd5, 32'h0001_0000, 32'h0000_0030, 32'h0, 16'h0008, 1'b0);
        chk("R3 pos", ea_o, 32'h0001_0038);
        apply(4'd5, 32'h0001_0000, 32'h0000_0030, 32'h0, 16'hFFFC, 1'b0);
        chk("R3 neg", ea_o, 32'h0001_002C);
    endtask

    task automatic t_pcrel_R4();
        apply(4'd6, 32'h5, 32'h6, 32'd1016, 16'hFFF0, 1'b1);
        chk("R4 back", ea_o, 32'd1000);
        apply(4'd6, 32'h5, 32'h6, 32'd1016, 16'd40, 1'b1);
        chk("R4 fwd", ea_o, 32'd1056);
    endtask

    task automatic t_postinc_R6_R8();
        apply(4'd7, 32'h0000_0100, 32'h0, 32'h0, 16'h0, 1'b1);
        chk("R6 ea word", ea_o, 32'h0000_0100);
        chk("R8 wb word", wb_data_o, 32'h0000_0104);
        chk("R11 wb_en inc", {31'd0, wb_en_o}, 32'h1);
        apply(4'd7, 32'h0000_0100, 32'h0, 32'h0, 16'h0, 1'b0);
        chk("R6 ea byte", ea_o, 32'h0000_0100);
        chk("R8 wb byte", wb_data_o, 32'h0000_0101);
    endtask

    task automatic t_predec_R7_R8();
        apply(4'd8, 32'd2000, 32'h0, 32'h0, 16'h0, 1'b1);
        chk("R7 ea word", ea_o, 32'd1996);
        chk("R7 wb word", wb_data_o, 32'd1996);
        chk("R11 wb_en dec", {31'd0, wb_en_o}, 32'h1);
        apply(4'd8, 32'd2000, 32'h0, 32'h0, 16'h0, 1'b0);
        chk("R8 ea byte", ea_o, 32'd1999);
        chk("R8 wb byte", wb_data_o, 32'd1999);
    endtask

    task automatic t_wrap_R12();
        apply(4'd8, 32'h0000_0002, 32'h0, 32'h0, 16'h0, 1'b1);
        chk("R12 dec wrap", ea_o, 32'hFFFF_FFFE);
        chk("R12 dec wb", wb_data_o, 32'hFFFF_FFFE);
        apply(4'd7, 32'hFFFF_FFFE, 32'h0, 32'h0, 16'h0, 1'b1);
        chk("R12 inc wrap", wb_data_o, 32'h0000_0002);
        apply(4'd5, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 16'h0004, 1'b0);
        chk("R12 sum wrap", ea_o, 32'h0000_0014);
        apply(4'd6, 32'h0, 32'h0, 32'h0000_0004, 16'hFFF0, 1'b0);
        chk("R12 pc wrap", ea_o, 32'h4 + sx(16'hFFF0));
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_idle_R13();
        t_immediate_R10();
        t_absolute_R9();
        t_indirect_R5();
        t_index_R1();
        t_baseidx_R2_R3();
        t_pcrel_R4();
        t_postinc_R6_R8();
        t_predec_R7_R8();
        t_wrap_R12();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule